// File: doc/BRIEF.md
# Vectored Prioritized Interrupt Controller

This block gathers thirty-two interrupt inputs and presents one active-high request line to a processor. Software sets up each source through a register interface. A per-source mode word selects the trigger kind and a 3-bit priority, and a per-source vector word holds the value returned when that source is acknowledged. Separate command words enable and disable sources with write-one semantics. Another command word discards latched edges, and a readable mask shows which sources are enabled.

The processor acknowledges an interrupt by reading the vector word. The read returns the vector of the best pending enabled source, and it records that source's priority on an eight-entry nesting stack. A write of any value to the end-of-interrupt word pops the stack. While the stack holds an entry, only a source whose priority is strictly above the entry on top can raise the request line again. When no source qualifies, the vector read returns the programmed spurious value and changes no state.

Top module: `intc_top`

## Requirements
- R1: A write to the enable command (word address 65) sets every enable bit whose data bit is 1. A write to the disable command (word 66) clears every enable bit whose data bit is 1. Zero data bits leave enable bits unchanged. Word 67 reads back the enable mask, with bit n for source n.
- R2: Mode word n (address n, 0..31) stores the priority in bits [2:0] and the trigger kind in bits [5:4]. The trigger codes are 0 for high level, 1 for rising edge, 2 for low level and 3 for falling edge. A read returns both fields and all other bits read 0.
- R3: Sources 0, 1 and 2 are external. On any other source, a mode write that carries trigger code 2 or 3 leaves the stored trigger kind unchanged, and the priority field is still written.
- R4: Each input passes through two synchronizing flops. A level-triggered source is pending while its input, inverted for the low-level kind, is active. A rising or falling edge, judged on the same inverted or non-inverted value, latches an edge-pending bit.
- R5: Reading the vector word (address 64) while the request line is high returns vector word n (address 32+n) of the winning source and pushes that source's priority. The winner is the pending enabled source with the highest priority, where 7 ranks highest, and the lowest source number wins a tie.
- R6: Reading the vector word while the request line is low returns the spurious word (address 69) and changes no state.
- R7: An acknowledge clears the winner's edge-pending bit. A level source stays pending as long as its input remains active.
- R8: A write to the clear command (word 68) clears the edge-pending bit of every source whose data bit is 1.
- R9: The request line is high only when a pending enabled source exists and either the stack is empty or that source's priority is strictly greater than the priority on top of the stack.
- R10: Any write to the end-of-interrupt word (address 70) pops one stack entry. The stack holds 8 entries, so eight pops fully unwind it. A pop on an empty stack has no effect.
- R11: After reset all sources are disabled, the stack is empty, the request line is low, and every mode, vector and spurious word is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 32 | Raw interrupt inputs, one per source |
| bus_rd | input | 1 | Read strobe for the addressed word |
| bus_wr | input | 1 | Write strobe for the addressed word |
| bus_addr | input | 7 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as bus_rd, zero otherwise |
| irq_o | output | 1 | Active-high interrupt request |

## Verification
Read data and the request line are combinational from state, so both are compared in the same cycle as the access, just before the closing edge. Register writes, pushes and pops show up in the following cycle. A level change on an input first moves the request line two edges after it is driven, because of the synchronizer. An edge first moves it three edges later, because the edge-pending flop adds one more stage. The bench's behavioural model applies the same sampling history and compares every cycle at that one sample point. The directed sequences leave at least three idle cycles after each input change before they read the vector word.

// File: rtl/intc_pkg.sv
package intc_pkg;
  typedef enum logic [1:0] {
    TRG_HIGH = 2'd0,
    TRG_RISE = 2'd1,
    TRG_LOW  = 2'd2,
    TRG_FALL = 2'd3
  } trg_e;

  localparam int TRG_LSB = 4;

  localparam logic [2:0] CTL_VEC  = 3'd0;
  localparam logic [2:0] CTL_ENA  = 3'd1;
  localparam logic [2:0] CTL_DIS  = 3'd2;
  localparam logic [2:0] CTL_MASK = 3'd3;
  localparam logic [2:0] CTL_CLR  = 3'd4;
  localparam logic [2:0] CTL_SPUR = 3'd5;
  localparam logic [2:0] CTL_EOI  = 3'd6;

  function automatic logic trg_is_edge(input logic [1:0] t);
    return t[0];
  endfunction

  function automatic logic trg_inverts(input logic [1:0] t);
    return t[1];
  endfunction
endpackage

// File: rtl/intc_src_slice.sv
module intc_src_slice
  import intc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       src,
  input  logic [1:0] trg,
  input  logic       clr,
  output logic       pend
);
  logic s1_q, s2_q, prev_q, ep_q;
  logic eff_now, eff_old, edge_hit;

  assign eff_now  = s2_q ^ trg_inverts(trg);
  assign eff_old  = prev_q ^ trg_inverts(trg);
  assign edge_hit = trg_is_edge(trg) & eff_now & ~eff_old;
  assign pend     = trg_is_edge(trg) ? ep_q : eff_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= 1'b0;
      s2_q   <= 1'b0;
      prev_q <= 1'b0;
      ep_q   <= 1'b0;
    end else begin
      s1_q   <= src;
      s2_q   <= s1_q;
      prev_q <= s2_q;
      if (edge_hit)  ep_q <= 1'b1;
      else if (clr)  ep_q <= 1'b0;
    end
  end
endmodule

// File: rtl/intc_arbiter.sv
module intc_arbiter #(
  parameter int NSRC = 32,
  parameter int PW   = 3,
  localparam int IDW = $clog2(NSRC)
) (
  input  logic [NSRC-1:0]    req,
  input  logic [NSRC*PW-1:0] prio_flat,
  output logic               win_valid,
  output logic [IDW-1:0]     win_id,
  output logic [PW-1:0]      win_prio
);
  always_comb begin
    win_valid = 1'b0;
    win_id    = '0;
    win_prio  = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (req[i] && (!win_valid || prio_flat[i*PW +: PW] > win_prio)) begin
        win_valid = 1'b1;
        win_id    = IDW'(i);
        win_prio  = prio_flat[i*PW +: PW];
      end
    end
  end
endmodule

// File: rtl/intc_stack.sv
module intc_stack #(
  parameter int DEPTH = 8,
  parameter int PW    = 3,
  localparam int SPW  = $clog2(DEPTH + 1),
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           push,
  input  logic           pop,
  input  logic [PW-1:0]  push_prio,
  output logic           empty,
  output logic           full,
  output logic [PW-1:0]  top_prio,
  output logic [SPW-1:0] level
);
  logic [PW-1:0] ent_q [DEPTH];

  assign empty    = (level == '0);
  assign full     = (level == SPW'(DEPTH));
  assign top_prio = empty ? '0 : ent_q[level[IW-1:0] - IW'(1)];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level <= '0;
      for (int i = 0; i < DEPTH; i++) ent_q[i] <= '0;
    end else if (push && !full) begin
      ent_q[level[IW-1:0]] <= push_prio;
      level <= level + SPW'(1);
    end else if (pop && !empty) begin
      level <= level - SPW'(1);
    end
  end
endmodule

// File: rtl/intc_top.sv
module intc_top
  import intc_pkg::*;
#(
  parameter int NSRC = 32,
  parameter int PW   = 3,
  parameter int DEPTH = 8,
  parameter int DW   = 32,
  parameter int AW   = 7,
  parameter logic [NSRC-1:0] EXT_SRC = NSRC'(7)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_i,
  input  logic            bus_rd,
  input  logic            bus_wr,
  input  logic [AW-1:0]   bus_addr,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  output logic            irq_o
);
  localparam int IDW = $clog2(NSRC);
  localparam int SPW = $clog2(DEPTH + 1);
  localparam logic [NSRC-1:0] EXT_EFF = EXT_SRC | NSRC'(1);

  logic [PW-1:0]      prio_q [NSRC];
  logic [1:0]         trg_q  [NSRC];
  logic [DW-1:0]      vec_q  [NSRC];
  logic [DW-1:0]      spur_q;
  logic [NSRC-1:0]    en_q;

  logic [NSRC-1:0]    pend, req, clr_vec;
  logic [NSRC*PW-1:0] prio_flat;
  logic               cand_v;
  logic [IDW-1:0]     cand_id;
  logic [PW-1:0]      cand_p, top_p;
  logic               stk_empty, stk_full;
  logic [SPW-1:0]     stk_level;

  logic [1:0]     region;
  logic [IDW-1:0] idx;
  logic [2:0]     sel;
  logic mode_wr, vec_wr, ctl_wr, ctl_rd;
  logic ena_wr, dis_wr, clr_wr, spur_wr, eoi, vec_rd, ack;

  assign region  = bus_addr[AW-1 -: 2];
  assign idx     = bus_addr[IDW-1:0];
  assign sel     = bus_addr[2:0];
  assign mode_wr = bus_wr && region == 2'd0;
  assign vec_wr  = bus_wr && region == 2'd1;
  assign ctl_wr  = bus_wr && region == 2'd2;
  assign ctl_rd  = bus_rd && region == 2'd2;
  assign ena_wr  = ctl_wr && sel == CTL_ENA;
  assign dis_wr  = ctl_wr && sel == CTL_DIS;
  assign clr_wr  = ctl_wr && sel == CTL_CLR;
  assign spur_wr = ctl_wr && sel == CTL_SPUR;
  assign eoi     = ctl_wr && sel == CTL_EOI;
  assign vec_rd  = ctl_rd && sel == CTL_VEC;

  assign req   = pend & en_q;
  assign irq_o = cand_v && (stk_empty || cand_p > top_p);
  assign ack   = vec_rd && irq_o && !stk_full;

  assign clr_vec = (clr_wr ? bus_wdata[NSRC-1:0] : '0)
                 | (ack ? (NSRC'(1) << cand_id) : '0);

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    intc_src_slice u_slice (
      .clk  (clk),
      .rst_n(rst_n),
      .src  (src_i[g]),
      .trg  (trg_q[g]),
      .clr  (clr_vec[g]),
      .pend (pend[g])
    );
    assign prio_flat[g*PW +: PW] = prio_q[g];
  end

  intc_arbiter #(.NSRC(NSRC), .PW(PW)) u_arb (
    .req      (req),
    .prio_flat(prio_flat),
    .win_valid(cand_v),
    .win_id   (cand_id),
    .win_prio (cand_p)
  );

  intc_stack #(.DEPTH(DEPTH), .PW(PW)) u_stk (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (ack),
    .pop      (eoi),
    .push_prio(cand_p),
    .empty    (stk_empty),
    .full     (stk_full),
    .top_prio (top_p),
    .level    (stk_level)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      spur_q <= '0;
      for (int i = 0; i < NSRC; i++) begin
        prio_q[i] <= '0;
        trg_q[i]  <= TRG_HIGH;
        vec_q[i]  <= '0;
      end
    end else begin
      if (ena_wr)  en_q   <= en_q | bus_wdata[NSRC-1:0];
      if (dis_wr)  en_q   <= en_q & ~bus_wdata[NSRC-1:0];
      if (spur_wr) spur_q <= bus_wdata;
      if (vec_wr)  vec_q[idx] <= bus_wdata;
      if (mode_wr) begin
        prio_q[idx] <= bus_wdata[PW-1:0];
        if (EXT_EFF[idx] || !bus_wdata[TRG_LSB+1])
          trg_q[idx] <= bus_wdata[TRG_LSB +: 2];
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      case (region)
        2'd0: begin
          bus_rdata[PW-1:0]        = prio_q[idx];
          bus_rdata[TRG_LSB +: 2]  = trg_q[idx];
        end
        2'd1: bus_rdata = vec_q[idx];
        2'd2: begin
          case (sel)
            CTL_VEC:  bus_rdata = ack ? vec_q[cand_id] : spur_q;
            CTL_MASK: bus_rdata = DW'(en_q);
            CTL_SPUR: bus_rdata = spur_q;
            default:  bus_rdata = '0;
          endcase
        end
        default: bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/intc_chk.sv
module intc_chk #(
  parameter int NSRC  = 32,
  parameter int DEPTH = 8,
  parameter int DW    = 32,
  parameter int SPW   = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            irq,
  input logic [NSRC-1:0] req,
  input logic [SPW-1:0]  level,
  input logic            ack,
  input logic            eoi,
  input logic            ena_wr,
  input logic [DW-1:0]   wdata,
  input logic [NSRC-1:0] mask,
  input logic            vec_rd,
  input logic [DW-1:0]   rdata,
  input logic [DW-1:0]   spur
);
  AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (req != '0));  // R9
  AST_FULL_BLOCKS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (level == SPW'(DEPTH)) |-> !irq);  // R9
  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    level <= SPW'(DEPTH));  // R10
  AST_ACK_PUSHES: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> level == $past(level) + SPW'(1));  // R5
  AST_EOI_POPS: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi && !ack && level != '0) |=> level == $past(level) - SPW'(1));  // R10
  AST_ENABLE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    ena_wr |=> (mask & $past(wdata[NSRC-1:0])) == $past(wdata[NSRC-1:0]));  // R1
  AST_SPUR_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_rd && !ack) |-> rdata == spur);  // R6
endmodule

bind intc_top intc_chk #(
  .NSRC (NSRC),
  .DEPTH(DEPTH),
  .DW   (DW),
  .SPW  (SPW)
) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .irq   (irq_o),
  .req   (req),
  .level (stk_level),
  .ack   (ack),
  .eoi   (eoi),
  .ena_wr(ena_wr),
  .wdata (bus_wdata),
  .mask  (en_q),
  .vec_rd(vec_rd),
  .rdata (bus_rdata),
  .spur  (spur_q)
);

// File: tb/tb_intc_top.sv
`timescale 1ns/100ps
module tb_intc_top;
  localparam logic [31:0] EXT = 32'h7;
  localparam logic [6:0] A_VEC = 7'd64, A_ENA = 7'd65, A_DIS = 7'd66, A_MASK = 7'd67,
                         A_CLR = 7'd68, A_SPUR = 7'd69, A_EOI = 7'd70;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [31:0] src = '0, wd = '0;
  logic rd = 1'b0, wr = 1'b0;
  logic [6:0] addr = '0;
  logic [31:0] rdata;
  logic irq;
  int vectors = 0, fails = 0;

  always #2 clk = ~clk;

  intc_top dut (
    .clk(clk), .rst_n(rst_n), .src_i(src), .bus_rd(rd), .bus_wr(wr),
    .bus_addr(addr), .bus_wdata(wd), .bus_rdata(rdata), .irq_o(irq)
  );

  // behavioural reference model
  bit [31:0] m_en, m_ep, h1, h2, h3;
  int m_prio[32], m_trg[32];
  logic [31:0] m_vec[32], m_spur;
  int stk[$];
  bit m_irq, m_cv;
  int m_cid;

  function automatic bit eff(int i, logic [31:0] v);
    return v[i] ^ (m_trg[i] >= 2);
  endfunction

  function automatic bit pend(int i);
    return (m_trg[i] % 2 == 1) ? m_ep[i] : eff(i, h2);
  endfunction

  task automatic model_reset();
    m_en = '0; m_ep = '0; h1 = '0; h2 = '0; h3 = '0; m_spur = '0;
    stk.delete();
    for (int i = 0; i < 32; i++) begin
      m_prio[i] = 0; m_trg[i] = 0; m_vec[i] = '0;
    end
  endtask

  task automatic model_eval();
    int best;
    m_cv = 0; m_cid = 0; best = -1;
    for (int i = 0; i < 32; i++)
      if (m_en[i] && pend(i) && m_prio[i] > best) begin
        m_cv = 1; m_cid = i; best = m_prio[i];
      end
    m_irq = m_cv && (stk.size() == 0 || best > stk[stk.size()-1]);
  endtask

  function automatic logic [31:0] exp_read(logic [6:0] a);
    if (a < 32) return {26'd0, 2'(m_trg[a]), 1'b0, 3'(m_prio[a])};
    if (a < 64) return m_vec[a-32];
    case (a)
      A_VEC:  return (m_irq && stk.size() < 8) ? m_vec[m_cid] : m_spur;
      A_MASK: return m_en;
      A_SPUR: return m_spur;
      default: return '0;
    endcase
  endfunction

  task automatic model_edge();
    bit ack;
    bit [31:0] nep;
    ack = rd && addr == A_VEC && m_irq && stk.size() < 8;
    nep = m_ep;
    if (wr && addr == A_CLR) nep &= ~wd;
    if (ack) nep[m_cid] = 1'b0;
    for (int i = 0; i < 32; i++)
      if (m_trg[i] % 2 == 1 && eff(i, h2) && !eff(i, h3)) nep[i] = 1'b1;
    if (wr) begin
      if (addr < 32) begin
        m_prio[addr] = int'(wd[2:0]);
        if (EXT[addr] || addr == 0 || !wd[5]) m_trg[addr] = int'(wd[5:4]);
      end else if (addr < 64) m_vec[addr-32] = wd;
      else case (addr)
        A_ENA:  m_en |= wd;
        A_DIS:  m_en &= ~wd;
        A_SPUR: m_spur = wd;
        A_EOI:  if (stk.size() > 0) void'(stk.pop_back());
        default: ;
      endcase
    end
    if (ack) stk.push_back(m_prio[m_cid]);
    m_ep = nep;
    h3 = h2; h2 = h1; h1 = src;
  endtask

  // one bus cycle: inputs already driven after a falling edge
  task automatic step(string tag);
    logic [31:0] er;
    #1;
    model_eval();
    vectors++;
    if (irq !== m_irq) begin
      fails++;
      $display("FAIL %s irq: got %0b exp %0b (addr %0d)", tag, irq, m_irq, addr);
    end
    if (rd) begin
      er = exp_read(addr);
      vectors++;
      if (rdata !== er) begin
        fails++;
        $display("FAIL %s rdata @%0d: got %h exp %h", tag, addr, rdata, er);
      end
    end
    @(posedge clk);
    model_edge();
    @(negedge clk);
  endtask

  task automatic wreg(logic [6:0] a, logic [31:0] d, string tag);
    wr = 1'b1; addr = a; wd = d;
    step(tag);
    wr = 1'b0; wd = '0;
  endtask

  task automatic rreg(logic [6:0] a, string tag);
    rd = 1'b1; addr = a;
    step(tag);
    rd = 1'b0;
  endtask

  task automatic idle(int n, string tag);
    for (int k = 0; k < n; k++) step(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R11 reset state
    rreg(A_MASK, "R11");
    rreg(A_VEC, "R11");
    rreg(7'd5, "R11");
    // vectors and spurious word
    for (int i = 0; i < 32; i++) wreg(7'(32 + i), 32'h100 + i, "R5");
    wreg(A_SPUR, 32'hDEAD, "R6");
    // modes: R2 readback, R3 restriction
    wreg(7'd5, 32'h13, "R2");   // rising, prio 3
    wreg(7'd6, 32'h03, "R2");   // high level, prio 3
    wreg(7'd1, 32'h25, "R2");   // low level, prio 5 (external)
    wreg(7'd2, 32'h31, "R2");   // falling, prio 1 (external)
    wreg(7'd9, 32'h22, "R3");   // low on internal: type kept
    rreg(7'd9, "R3");
    wreg(7'd9, 32'h32, "R3");
    rreg(7'd9, "R3");
    rreg(7'd1, "R2");
    rreg(7'd2, "R2");
    // R1 enable/disable
    wreg(A_ENA, 32'h266, "R1");
    wreg(A_DIS, 32'h200, "R1");
    rreg(A_MASK, "R1");
    wreg(A_ENA, 32'h0, "R1");
    wreg(A_DIS, 32'h0, "R1");
    rreg(A_MASK, "R1");
    // R4 low level active with input low
    idle(3, "R4");
    rreg(A_VEC, "R5");
    src[5] = 1'b1; src[6] = 1'b1;
    idle(4, "R9");
    src[1] = 1'b1;
    idle(3, "R4");
    wreg(A_EOI, 32'h0, "R10");
    rreg(A_VEC, "R5");          // tie prio 3: source 5 wins
    wreg(A_EOI, 32'h0, "R10");
    idle(1, "R7");
    rreg(A_VEC, "R7");          // level source 6 still pending
    wreg(A_EOI, 32'h0, "R10");
    src[6] = 1'b0;
    idle(3, "R7");
    rreg(A_VEC, "R6");
    // R8 clear of a latched edge
    src[5] = 1'b0; idle(2, "R8");
    src[5] = 1'b1; idle(3, "R8");
    wreg(A_CLR, 32'h20, "R8");
    idle(2, "R8");
    rreg(A_VEC, "R8");
    // R4 falling edge on external source 2
    src[2] = 1'b1; idle(3, "R4");
    src[2] = 1'b0; idle(3, "R4");
    rreg(A_VEC, "R4");
    wreg(A_EOI, 32'h0, "R10");
    // R10 full nesting, R9 strict preemption
    for (int k = 0; k < 9; k++) wreg(7'(10 + k), 32'h10 | (k > 7 ? 7 : k), "R10");
    wreg(A_ENA, 32'h7FC00, "R10");
    for (int k = 0; k < 8; k++) begin
      src[10 + k] = 1'b1;
      idle(3, "R10");
      rreg(A_VEC, "R10");
    end
    src[18] = 1'b1;
    idle(4, "R9");
    rreg(A_VEC, "R9");
    for (int k = 0; k < 10; k++) begin
      wreg(A_EOI, 32'h0, "R10");
      rreg(A_VEC, "R10");
    end
    idle(2, "R10");
    // mixed traffic
    for (int n = 0; n < 600; n++) begin
      int op;
      op = $urandom_range(0, 9);
      case (op)
        0, 1, 2: begin src[$urandom_range(0, 31)] ^= 1'b1; idle(1, "R4"); end
        3: rreg(A_VEC, "R5");
        4: rreg(A_MASK, "R1");
        5: wreg(A_ENA, $urandom, "R1");
        6: wreg(A_DIS, $urandom, "R1");
        7: wreg(A_CLR, $urandom, "R8");
        8: wreg(A_EOI, $urandom, "R10");
        default: wreg(7'($urandom_range(0, 31)), 32'($urandom_range(0, 63)), "R3");
      endcase
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule